// File: doc/BRIEF.md
# Thread Priority Interrupt Steering Unit

This block sits beside a multithreaded core with up to eight hardware threads. Each thread reports its current priority, where a larger number means less important work. When an interrupt arrives, the unit hands it to the eligible thread that is doing the least important work, so that urgent threads keep running. If no thread can take the interrupt, the request is held until one can.

The unit also helps the guest OS scheduler. Software writes a best-waiting priority, which is the priority of the most important task that is ready but not yet running. While scheduling assistance is enabled, the unit compares every thread's priority against that value. If any running thread is worse, it raises a one-cycle reschedule interrupt. At the same time it returns the best-waiting value to its idle code 0x1ff, so the interrupt cannot repeat until software writes a new value.

Top module: `prio_steer_unit`

## Requirements
- R1: After synchronous reset, `irq_grant` is all zeros, `resched_irq` is 0 and `bw_rd` reads 0x1ff.
- R2: An interrupt request is granted on the clock edge that samples it together with at least one eligible thread. In the following cycle `irq_grant` is one-hot and selects the eligible thread with the numerically largest priority.
- R3: When several eligible threads share that largest priority, the grant goes to the lowest thread index.
- R4: A request made while no thread is eligible produces no grant and stays pending. Further arrivals while it is pending merge into it. It is granted on the first edge at which some thread is eligible.
- R5: Each granted request drives `irq_grant` for exactly one cycle. With no request pending or arriving, `irq_grant` is zero.
- R6: A write strobe stores `bw_wr_data` into the best-waiting register. `bw_rd` shows the new value in the next cycle.
- R7: When `sched_en` is 1 and any thread's priority is strictly greater than the stored best-waiting value, `resched_irq` pulses in the next cycle. Eligibility is not considered, and a priority equal to the stored value does not trigger it.
- R8: The edge that raises `resched_irq` also resets the best-waiting register to 0x1ff. Without a new write, no further pulse follows.
- R9: While `sched_en` is 0, no reschedule pulse is raised and the best-waiting register keeps its value.
- R10: If a write and a reschedule trigger fall on the same edge, the pulse is still raised and the written value is kept instead of 0x1ff.
- R11: Thread i's priority occupies bits [9i+8:9i] of `thr_prio`, and bit i of `thr_elig` and of `irq_grant` belongs to thread i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_prio | input | 72 | Packed per-thread priorities, 9 bits each, larger is worse |
| thr_elig | input | 8 | Per-thread eligibility to take an interrupt |
| irq_arrive | input | 1 | Interrupt arrival strobe |
| sched_en | input | 1 | Enables reschedule assistance |
| bw_wr_en | input | 1 | Best-waiting register write strobe |
| bw_wr_data | input | 9 | Best-waiting value to write |
| irq_grant | output | 8 | One-hot thread chosen for the interrupt |
| resched_irq | output | 1 | Single-cycle reschedule interrupt |
| bw_rd | output | 9 | Current best-waiting register value |

## Verification
The assertions assume that priorities, eligibility and the control strobes are stable and known at every clock edge. They also assume that `sched_en` and the eligibility mask start at zero during reset, because several properties look one cycle into the past. The stimulus changes every input only at the falling clock edge and keeps every input at a defined value from time zero. A behavioural model in the bench is updated on the same edges, and its state is compared with the outputs in every cycle after reset.

// File: rtl/steer_pkg.sv
// Package: shared defaults and types for the steering unit.
// Assumes: priorities are unsigned, larger value = less important.
package steer_pkg;
    localparam int DEF_THREADS = 8;
    localparam int DEF_PRIO_W  = 9;
endpackage

// File: rtl/steer_pick.sv
// Module: steer_pick
// Chooses, among eligible threads, the one with the numerically largest
// priority; ties resolve to the lowest index. Purely combinational.
// Assumes: prio_flat packs thread i at bits [i*PW +: PW].
module steer_pick #(
    parameter int NTHR = steer_pkg::DEF_THREADS,
    parameter int PW   = steer_pkg::DEF_PRIO_W
) (
    input  logic [NTHR*PW-1:0] prio_flat,
    input  logic [NTHR-1:0]    elig,
    output logic [NTHR-1:0]    pick_oh,
    output logic [PW-1:0]      pick_prio,
    output logic               pick_any
);
    logic [PW-1:0] tp [NTHR];

    // Unpack per-thread priority slices.
    for (genvar g = 0; g < NTHR; g++) begin : g_unpack
        assign tp[g] = prio_flat[g*PW +: PW];
    end

    // Linear scan: strict compare keeps the earliest of equal maxima.
    always_comb begin
        pick_oh   = '0;
        pick_prio = '0;
        pick_any  = 1'b0;
        for (int i = 0; i < NTHR; i++) begin
            if (elig[i] && (!pick_any || tp[i] > pick_prio)) begin
                pick_oh    = '0;
                pick_oh[i] = 1'b1;
                pick_prio  = tp[i];
                pick_any   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/steer_grant.sv
// Module: steer_grant
// Holds a single pending interrupt request and registers a one-cycle grant
// to the picked thread once any thread is eligible.
// Assumes: pick_oh is one-hot whenever pick_any is set.
module steer_grant #(
    parameter int NTHR = steer_pkg::DEF_THREADS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arrive,
    input  logic [NTHR-1:0] pick_oh,
    input  logic            pick_any,
    output logic [NTHR-1:0] grant,
    output logic            pending
);
    logic req;

    // A request is live if one is waiting or one arrives now.
    assign req = pending | arrive;

    // Register the grant and keep the request while nobody can take it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant   <= '0;
            pending <= 1'b0;
        end else begin
            grant   <= (req && pick_any) ? pick_oh : '0;
            pending <= req && !pick_any;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R2
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !pick_any |=> pending && grant == '0); // R4
    AST_NO_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !pending && !arrive |=> grant == '0); // R5
    AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        grant != '0 |-> !pending); // R5
endmodule

// File: rtl/resched_ctl.sv
// Module: resched_ctl
// Keeps the best-waiting priority and raises a one-cycle reschedule pulse
// when enabled and any thread priority is worse than it; firing returns the
// register to all ones. A same-edge write takes precedence over that reset.
// Assumes: all-ones is the idle code, so nothing can be worse than it.
module resched_ctl #(
    parameter int NTHR = steer_pkg::DEF_THREADS,
    parameter int PW   = steer_pkg::DEF_PRIO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NTHR*PW-1:0] prio_flat,
    input  logic               sched_en,
    input  logic               wr_en,
    input  logic [PW-1:0]      wr_data,
    output logic               resched,
    output logic [PW-1:0]      bw_q
);
    localparam logic [PW-1:0] BW_IDLE = '1;

    logic [NTHR-1:0] worse;
    logic            fire;

    // Per-thread comparison against the stored best-waiting value.
    for (genvar g = 0; g < NTHR; g++) begin : g_cmp
        assign worse[g] = prio_flat[g*PW +: PW] > bw_q;
    end

    // Trigger when enabled and at least one thread is worse.
    assign fire = sched_en && (|worse);

    // Register pulse and best-waiting value; write wins over idle reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resched <= 1'b0;
            bw_q    <= BW_IDLE;
        end else begin
            resched <= fire;
            if (wr_en)
                bw_q <= wr_data;
            else if (fire)
                bw_q <= BW_IDLE;
        end
    end

    AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !sched_en |=> !resched); // R9
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !sched_en && !wr_en |=> $stable(bw_q)); // R9
    AST_IDLE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        resched && !$past(wr_en) |-> bw_q == BW_IDLE); // R8
    AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
        resched && !$past(wr_en) |=> !resched); // R8
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bw_q == $past(wr_data)); // R10
endmodule

// File: rtl/prio_steer_unit.sv
// Module: prio_steer_unit (top)
// Steers interrupts to the eligible thread running the least important work
// and raises reschedule interrupts against a software best-waiting value.
// Assumes: inputs are synchronous to clk; reset is synchronous, active low.
module prio_steer_unit #(
    parameter int NTHR = steer_pkg::DEF_THREADS,
    parameter int PW   = steer_pkg::DEF_PRIO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NTHR*PW-1:0] thr_prio,
    input  logic [NTHR-1:0]    thr_elig,
    input  logic               irq_arrive,
    input  logic               sched_en,
    input  logic               bw_wr_en,
    input  logic [PW-1:0]      bw_wr_data,
    output logic [NTHR-1:0]    irq_grant,
    output logic               resched_irq,
    output logic [PW-1:0]      bw_rd
);
    logic [NTHR-1:0] pick_oh;
    logic [PW-1:0]   pick_prio;
    logic            pick_any;
    logic            pending;

    steer_pick #(.NTHR(NTHR), .PW(PW)) u_pick (
        .prio_flat (thr_prio),
        .elig      (thr_elig),
        .pick_oh   (pick_oh),
        .pick_prio (pick_prio),
        .pick_any  (pick_any)
    );

    steer_grant #(.NTHR(NTHR)) u_grant (
        .clk      (clk),
        .rst_n    (rst_n),
        .arrive   (irq_arrive),
        .pick_oh  (pick_oh),
        .pick_any (pick_any),
        .grant    (irq_grant),
        .pending  (pending)
    );

    resched_ctl #(.NTHR(NTHR), .PW(PW)) u_resched (
        .clk       (clk),
        .rst_n     (rst_n),
        .prio_flat (thr_prio),
        .sched_en  (sched_en),
        .wr_en     (bw_wr_en),
        .wr_data   (bw_wr_data),
        .resched   (resched_irq),
        .bw_q      (bw_rd)
    );

    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_grant != '0 |-> (irq_grant & $past(thr_elig)) != '0); // R2

    // Picker checks against every thread's own priority slice.
    for (genvar g = 0; g < NTHR; g++) begin : g_chk
        AST_PICK_WORST: assert property (@(posedge clk) disable iff (!rst_n)
            thr_elig[g] |-> pick_any && thr_prio[g*PW +: PW] <= pick_prio); // R2
        AST_PICK_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            thr_elig[g] && thr_prio[g*PW +: PW] == pick_prio
            |-> (pick_oh >> (g + 1)) == '0); // R3
    end
endmodule

// File: tb/prio_steer_unit_test.sv
module prio_steer_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [71:0] thr_prio;
    logic [7:0]  thr_elig = '0;
    logic        irq_arrive = 1'b0;
    logic        sched_en = 1'b0;
    logic        bw_wr_en = 1'b0;
    logic [8:0]  bw_wr_data = '0;
    logic [7:0]  irq_grant;
    logic        resched_irq;
    logic [8:0]  bw_rd;
    logic [8:0]  p [8];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0] m_grant;
    logic       m_res;
    logic [8:0] m_bw;
    logic       m_pend;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) thr_prio[i*9 +: 9] = p[i];
    end

    prio_steer_unit uut (
        .clk(clk), .rst_n(rst_n), .thr_prio(thr_prio), .thr_elig(thr_elig),
        .irq_arrive(irq_arrive), .sched_en(sched_en), .bw_wr_en(bw_wr_en),
        .bw_wr_data(bw_wr_data), .irq_grant(irq_grant),
        .resched_irq(resched_irq), .bw_rd(bw_rd)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        int  best;
        int  bval;
        bit  fire;
        bit  req;
        if (!rst_n) begin
            m_grant <= '0; m_res <= 1'b0; m_bw <= 9'h1ff; m_pend <= 1'b0;
        end else begin
            best = -1; bval = -1;
            for (int i = 0; i < 8; i++)
                if (thr_elig[i] && int'(p[i]) > bval) begin best = i; bval = int'(p[i]); end
            req = m_pend || irq_arrive;
            m_grant <= (req && best >= 0) ? 8'(1 << best) : 8'h00;
            m_pend  <= req && best < 0;
            fire = 1'b0;
            for (int i = 0; i < 8; i++) if (sched_en && p[i] > m_bw) fire = 1'b1;
            m_res <= fire;
            if (bw_wr_en) m_bw <= bw_wr_data;
            else if (fire) m_bw <= 9'h1ff;
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 grant vs model", irq_grant, m_grant);
            chk("R7 resched vs model", resched_irq, m_res);
            chk("R6 bw vs model", bw_rd, m_bw);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) p[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 grant", irq_grant, 0);
        chk("R1 resched", resched_irq, 0);
        chk("R1 bw", bw_rd, 9'h1ff);

        // R2: worst priority among all eligible
        for (int i = 0; i < 8; i++) p[i] = 9'(i * 10 + 5);
        thr_elig = 8'hff; irq_arrive = 1'b1;
        @(negedge clk); irq_arrive = 1'b0;
        chk("R2 worst thread", irq_grant, 8'h80);
        @(negedge clk);
        chk("R5 single pulse", irq_grant, 0);

        // R2: ineligible thread skipped
        thr_elig = 8'h7f; irq_arrive = 1'b1;
        @(negedge clk); irq_arrive = 1'b0;
        chk("R2 skip ineligible", irq_grant, 8'h40);

        // R3: tie to lowest index
        p[2] = 9'd300; p[5] = 9'd300; thr_elig = 8'hff; irq_arrive = 1'b1;
        @(negedge clk); irq_arrive = 1'b0;
        chk("R3 tie lowest", irq_grant, 8'h04);

        // R11: field position of thread 3
        for (int i = 0; i < 8; i++) p[i] = '0;
        p[3] = 9'h1ff; thr_elig = 8'h0f; irq_arrive = 1'b1;
        @(negedge clk); irq_arrive = 1'b0;
        chk("R11 field position", irq_grant, 8'h08);

        // R4: pending while nobody eligible, merged arrivals
        thr_elig = 8'h00; irq_arrive = 1'b1;
        @(negedge clk); irq_arrive = 1'b0;
        chk("R4 no eligible", irq_grant, 0);
        irq_arrive = 1'b1;
        @(negedge clk); irq_arrive = 1'b0;
        chk("R4 still held", irq_grant, 0);
        @(negedge clk);
        chk("R4 still held 2", irq_grant, 0);
        thr_elig = 8'h30;
        @(negedge clk);
        chk("R4 late grant", irq_grant, 8'h10);
        @(negedge clk);
        chk("R5 merged once", irq_grant, 0);

        // R6: write best-waiting
        for (int i = 0; i < 8; i++) p[i] = 9'd50;
        bw_wr_en = 1'b1; bw_wr_data = 9'd100;
        @(negedge clk); bw_wr_en = 1'b0;
        chk("R6 readback", bw_rd, 100);

        // R9: disabled, worse thread present
        p[6] = 9'd200;
        @(negedge clk);
        @(negedge clk);
        chk("R9 no pulse", resched_irq, 0);
        chk("R9 value kept", bw_rd, 100);

        // R7/R8: enabled, no thread eligible
        thr_elig = 8'h00; sched_en = 1'b1;
        @(negedge clk);
        chk("R7 pulse", resched_irq, 1);
        chk("R8 idle code", bw_rd, 9'h1ff);
        @(negedge clk);
        chk("R8 one cycle", resched_irq, 0);
        @(negedge clk);
        chk("R8 no refire", resched_irq, 0);

        // R7: equal priority does not trigger
        bw_wr_en = 1'b1; bw_wr_data = 9'd200;
        @(negedge clk); bw_wr_en = 1'b0;
        chk("R6 readback 200", bw_rd, 200);
        @(negedge clk);
        chk("R7 equal no pulse", resched_irq, 0);

        // R10: write and trigger on the same edge
        sched_en = 1'b0; bw_wr_en = 1'b1; bw_wr_data = 9'd100;
        @(negedge clk);
        sched_en = 1'b1; bw_wr_data = 9'd300;
        @(negedge clk); bw_wr_en = 1'b0;
        chk("R10 pulse", resched_irq, 1);
        chk("R10 write kept", bw_rd, 300);
        @(negedge clk);
        chk("R10 no repeat", resched_irq, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule